// File: doc/BRIEF.md
# Error Count Snapshot Controller

This block keeps a saturating running count of error events for each of several independent sources. It copies those counts into holding registers that a host can read at leisure. A copy is requested by a trigger level, which is the OR of a software control bit and an external strobe. The external strobe is asynchronous to the block clock and is only honoured while an enable input is high. A copy starts only on a rising edge of that combined trigger. The trigger must drop low again before a further copy can be started.

When a copy starts, the block raises a busy flag and waits a fixed, parameterised number of cycles. It then writes every holding register in the same cycle and restarts each running count. An error event that arrives in that same cycle is not dropped: it becomes the first count of the new interval. A one-cycle done pulse marks the cycle in which the new holding values are visible. The worst-case time from trigger edge to written holding registers is checked against a cycle budget when the block is elaborated. The block's users can therefore rely on a fixed read-after-trigger delay.

Top module: `errsnap_top`

## Requirements
- R1: After reset, all holding counts read 0, and busy and done are low.
- R2: When sw_update rises between two clock edges, the holding counts show the accumulated counts right after the third following rising edge. busy is high after the first of those edges and low after the third. done is high for exactly the one cycle after the third edge.
- R3: With ext_en high, a rise of ext_strobe between two clock edges writes the holding counts, and pulses done, right after the fifth following rising edge. This is two synchronizer stages plus the R2 path. done is still low after the fourth edge.
- R4: While ext_en is low, ext_strobe has no effect. busy stays low and the holding counts are unchanged, and events keep accumulating for the next copy.
- R5: A trigger that stays high causes only one copy. No further copy happens until the combined trigger has been low for at least one clock edge.
- R6: The trigger is the OR of sw_update and the enabled ext_strobe. A strobe rise while sw_update is already high is not a new edge and starts nothing.
- R7: An error event sampled on the copy edge is not lost. It is excluded from the values being copied and becomes a count of 1 in the new interval.
- R8: Each running count saturates at 2^CNT_W-1 and never wraps. The holding count then reads all ones.
- R9: busy rises on the clock edge after a trigger edge is seen and stays high until the holding registers are written.
- R10: A trigger edge seen while busy is high is ignored and produces no second done pulse.
- R11: The delay from trigger edge to holding write is bounded. busy never stays high for more than UPD_DELAY+1 cycles. The sum SYNC_STAGES+UPD_DELAY+2 must not exceed MAX_UPD_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_strobe | input | 1 | Asynchronous external copy request |
| ext_en | input | 1 | Allows ext_strobe to take part in the trigger |
| sw_update | input | 1 | Software copy request bit |
| err_evt | input | NUM_SRC | One error event pulse per source and cycle |
| hold_cnt | output | NUM_SRC*CNT_W | Holding counts, source i at bits [i*CNT_W +: CNT_W] |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse when the holding counts have been written |

## Verification
Every cycle, the embedded properties check the following. A seen edge must raise busy. busy must fall with a done pulse once the wait count reaches its limit. A saturated count must hold. A copy must leave each running count at 0 or 1. The holding registers must not move between copies. The exact edge-to-visibility latency of both trigger paths can only be shown by the bench's scenarios. The same is true of the values copied for varied event patterns, the ignored strobe when it is disabled, and single-shot behaviour under a held or overlapping trigger.

// File: rtl/errsnap_pkg.sv
package errsnap_pkg;

   typedef enum logic [0:0] {
      SNAP_IDLE = 1'b0,
      SNAP_WAIT = 1'b1
   } snap_state_e;

   function automatic int unsigned clog2_min1(input int unsigned v);
      int unsigned r;
      r = 1;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/errsnap_sync.sv
module errsnap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("errsnap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_async};
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/errsnap_trig.sv
module errsnap_trig
   import errsnap_pkg::*;
#(
   parameter int unsigned UPD_DELAY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_lvl,
   output logic busy,
   output logic snap,
   output logic done
);

   localparam int unsigned DLY_W = clog2_min1(UPD_DELAY + 1);

   logic        trig_q;
   logic        trig_edge;
   snap_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
      end else begin
         trig_q <= trig_lvl;
      end
   end

   assign trig_edge = trig_lvl & ~trig_q;
   assign busy      = (state_q == SNAP_WAIT);

   if (UPD_DELAY == 0) begin : g_nowait
      assign snap = busy;
   end else begin : g_wait
      logic [DLY_W-1:0] wait_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wait_q <= '0;
         end else if (!busy) begin
            wait_q <= '0;
         end else if (!snap) begin
            wait_q <= wait_q + 1'b1;
         end
      end

      assign snap = busy && (wait_q == DLY_W'(UPD_DELAY));

      // busy never outlasts the wait limit (R11)
      assert_wait_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
         busy |-> (wait_q <= DLY_W'(UPD_DELAY)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SNAP_IDLE;
         done    <= 1'b0;
      end else begin
         done <= snap;
         if (snap) begin
            state_q <= SNAP_IDLE;
         end else if (trig_edge && !busy) begin
            state_q <= SNAP_WAIT;
         end
      end
   end

   assert_busy_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_edge && !busy) |=> busy);

   assert_snap_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> (!busy && done));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/errsnap_acc.sv
module errsnap_acc #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             snap,
   output logic [CNT_W-1:0] hold
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         hold  <= '0;
      end else if (snap) begin
         hold  <= run_q;
         run_q <= {{(CNT_W-1){1'b0}}, evt};
      end else if (evt && (run_q != CNT_MAX)) begin
         run_q <= run_q + 1'b1;
      end
   end

   assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == CNT_MAX && !snap) |=> (run_q == CNT_MAX));

   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> (run_q <= CNT_W'(1)));

   assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(hold));

endmodule

// File: rtl/errsnap_top.sv
module errsnap_top #(
   parameter int unsigned NUM_SRC     = 4,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned UPD_DELAY   = 1,
   parameter int unsigned MAX_UPD_CYC = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ext_strobe,
   input  logic                     ext_en,
   input  logic                     sw_update,
   input  logic [NUM_SRC-1:0]       err_evt,
   output logic [NUM_SRC*CNT_W-1:0] hold_cnt,
   output logic                     busy,
   output logic                     done
);

   localparam int unsigned WORST_CYC = SYNC_STAGES + UPD_DELAY + 2;

   if (NUM_SRC < 1) begin : g_bad_src
      $error("errsnap_top: NUM_SRC must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("errsnap_top: CNT_W must be at least 2");
   end
   if (WORST_CYC > MAX_UPD_CYC) begin : g_bad_lat
      $error("errsnap_top: update latency exceeds MAX_UPD_CYC (R11)");
   end

   logic strobe_sync;
   logic trig_lvl;
   logic snap;

   errsnap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (ext_strobe),
      .q_sync  (strobe_sync)
   );

   assign trig_lvl = sw_update | (ext_en & strobe_sync);

   errsnap_trig #(.UPD_DELAY(UPD_DELAY)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_lvl (trig_lvl),
      .busy     (busy),
      .snap     (snap),
      .done     (done)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      errsnap_acc #(.CNT_W(CNT_W)) u_acc (
         .clk   (clk),
         .rst_n (rst_n),
         .evt   (err_evt[i]),
         .snap  (snap),
         .hold  (hold_cnt[i*CNT_W +: CNT_W])
      );
   end

   assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_update && !ext_en && !busy) |=> !busy);

endmodule

// File: tb/sim_errsnap_top.sv
module sim_errsnap_top;

   localparam int NSRC = 4;
   localparam int CW   = 4;
   localparam int CMAX = (1 << CW) - 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 ext_strobe = 1'b0;
   logic                 ext_en = 1'b0;
   logic                 sw_update = 1'b0;
   logic [NSRC-1:0]      err_evt = '0;
   logic [NSRC*CW-1:0]   hold_cnt;
   logic                 busy;
   logic                 done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   errsnap_top #(.NUM_SRC(NSRC), .CNT_W(CW), .SYNC_STAGES(2), .UPD_DELAY(1),
                 .MAX_UPD_CYC(10)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_strobe(ext_strobe), .ext_en(ext_en),
      .sw_update(sw_update), .err_evt(err_evt), .hold_cnt(hold_cnt),
      .busy(busy), .done(done)
   );

   always #5 clk = ~clk;

   // entry: bit 20 = use external strobe, bits [i*5 +: 5] = event count of source i
   localparam logic [20:0] VEC [6] = '{
      {1'b0, 5'd1, 5'd7, 5'd0, 5'd3},
      {1'b1, 5'd2, 5'd16, 5'd15, 5'd20},
      {1'b0, 5'd0, 5'd0, 5'd0, 5'd0},
      {1'b1, 5'd4, 5'd3, 5'd2, 5'd1},
      {1'b0, 5'd0, 5'd1, 5'd14, 5'd15},
      {1'b1, 5'd31, 5'd0, 5'd5, 5'd9}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int hold_of(input int i);
      return int'(hold_cnt[i*CW +: CW]);
   endfunction

   task automatic drive_events(input logic [19:0] cnts);
      for (int k = 0; k < 32; k++) begin
         logic [NSRC-1:0] m;
         for (int i = 0; i < NSRC; i++) m[i] = (k < int'(cnts[i*5 +: 5]));
         if (m == '0) break;
         @(negedge clk) err_evt = m;
      end
      @(negedge clk) err_evt = '0;
   endtask

   task automatic snap_sw(input string req);
      @(negedge clk) sw_update = 1'b1;
      @(negedge clk) chk({req, "/R9 busy after 1st edge"}, busy, 1);
      @(negedge clk) chk({req, " done after 2nd edge"}, done, 0);
      @(negedge clk) chk({req, " done after 3rd edge"}, done, 1);
      chk({req, "/R9 busy after write"}, busy, 0);
      sw_update = 1'b0;
      @(negedge clk) chk({req, " done single pulse"}, done, 0);
   endtask

   task automatic snap_ext(input string req);
      @(negedge clk) ext_strobe = 1'b1;
      repeat (4) @(negedge clk);
      chk({req, " done after 4th edge"}, done, 0);
      @(negedge clk) chk({req, " done after 5th edge"}, done, 1);
      ext_strobe = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int cnt;
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int i = 0; i < NSRC; i++) chk("R1 hold reset", hold_of(i), 0);
      chk("R1 busy reset", busy, 0);
      chk("R1 done reset", done, 0);
      rst_n = 1'b1;
      ext_en = 1'b1;
      @(negedge clk);

      // vector table: R2 (sw), R3 (ext), R8 saturation
      for (int v = 0; v < 6; v++) begin
         drive_events(VEC[v][19:0]);
         if (VEC[v][20]) snap_ext("R3 ext copy");
         else            snap_sw("R2 sw copy");
         for (int i = 0; i < NSRC; i++) begin
            cnt = int'(VEC[v][i*5 +: 5]);
            chk("R8/R2 held count", hold_of(i), (cnt > CMAX) ? CMAX : cnt);
         end
      end

      // R4: strobe ignored when disabled; counts keep accumulating
      ext_en = 1'b0;
      drive_events(20'h00002);
      @(negedge clk) ext_strobe = 1'b1;
      repeat (7) begin
         @(negedge clk) if (busy) chk("R4 busy while disabled", busy, 0);
      end
      chk("R4 hold unchanged", hold_of(0), 9);
      ext_strobe = 1'b0;
      snap_sw("R4 follow-up");
      chk("R4 accumulated kept", hold_of(0), 2);

      // R5/R6: held trigger fires once; strobe under held sw adds no edge
      ext_en = 1'b1;
      drive_events(20'h00001);
      @(negedge clk) sw_update = 1'b1;
      repeat (4) @(negedge clk);
      chk("R5 first copy", hold_of(0), 1);
      drive_events(20'h00003);
      ext_strobe = 1'b1;
      cnt = 0;
      repeat (10) begin
         @(negedge clk) if (done) cnt++;
      end
      ext_strobe = 1'b0;
      chk("R5/R6 no extra copy", cnt, 0);
      chk("R5 hold unchanged", hold_of(0), 1);
      sw_update = 1'b0;
      repeat (4) @(negedge clk);
      snap_sw("R5 rearmed");
      chk("R5 rearmed count", hold_of(0), 3);

      // R7: event on the copy edge starts the new interval
      drive_events(20'h00002);
      @(negedge clk) sw_update = 1'b1;
      @(negedge clk);
      @(negedge clk) err_evt = 4'b0001;
      @(negedge clk) err_evt = '0;
      chk("R7 copied excludes edge event", hold_of(0), 2);
      sw_update = 1'b0;
      @(negedge clk);
      snap_sw("R7 next");
      chk("R7 edge event kept", hold_of(0), 1);

      // R10: edge during busy ignored
      @(negedge clk) sw_update = 1'b1;
      @(negedge clk) sw_update = 1'b0;
      @(negedge clk) sw_update = 1'b1;
      @(negedge clk) chk("R10 first done", done, 1);
      cnt = 0;
      repeat (8) begin
         @(negedge clk) if (done) cnt++;
      end
      chk("R10 no second done", cnt, 0);
      sw_update = 1'b0;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule